// File: doc/BRIEF.md
# Event Performance Monitor

This block counts hardware events for profiling. Four 32-bit event counters each pick one strobe from an incoming vector of single-cycle event pulses through their own selector register. A 64-bit cycle counter runs inside a window that opens on a programmable start event and closes on a programmable stop event.

Software reaches the block through a simple word-addressed register port. A write is a single-cycle `reg_wr` strobe. Read data for the address on `reg_addr` is registered and appears one clock later.

The enable mask, the sticky overflow flags and the interrupt-enable mask each have a pair of registers, one that sets bits and one that clears them. A single interrupt line is raised while any overflow flag is set whose interrupt enable is also set.

Top module: `perf_monitor`

## Requirements
- R1: After reset every readable register reads 0 and `irq_o` is 0.
- R2: A selector value of 0 never counts. A value of 1 counts every clock. A value v from 2 to NUM_EVT+1 counts cycles in which `evt_i[v-2]` is high. Any larger value never counts. Selectors for counter i sit at address 32+i.
- R3: A counter advances only on clock edges where the global enable (address 0, bit 0) and its own enable bit are both 1. Counter i uses mask bit i and the cycle counter uses mask bit 31.
- R4: Address 1 sets and address 2 clears enable bits, address 3 sets and 4 clears overflow flags, and address 5 sets and 6 clears interrupt enables. In each case only bits written as 1 change. Both addresses of a pair read the current mask, and mask bits other than 0..3 and 31 read as 0.
- R5: Writing 1 to address 0 bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. These two bits read back as 0.
- R6: Event counter i is read and written at address 16+i. A software write in the same cycle as an increment takes the written value.
- R7: A counter that wraps from all ones to zero sets its overflow flag. The flag stays set until it is cleared through address 4.
- R8: `irq_o` goes high one clock after any bit of (overflow AND interrupt enable) is set, and goes low one clock after none is set.
- R9: The cycle counter is 64 bits wide, with its low word at address 8 and its high word at address 9, and each word is writable. A carry out of the low word increments the high word.
- R10: Address 10 holds the start event number in bits 9:0 and the stop event number in bits 25:16, decoded as in R2. A start event opens the window from the next clock on, and the stop edge is still counted. A stop wins over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| evt_i | input | NUM_EVT | Single-cycle event strobes |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with NUM_EVT=4. With that setting, a sweep of selector values 0 to 7 on every counter covers the no-event code, the every-cycle code, each event line and the out-of-range codes. Each sweep result is compared with a bit count of the applied pattern, computed in the bench. Presetting counters and both cycle-counter words near all ones brings the 32-bit and 64-bit wraps, the carry into the high word, and the resulting interrupt within a few clocks. The same event lines also drive the start and stop window, including a start and a stop in the same cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int CYC_BIT = 31;
  localparam int STOP_LSB = 16;
  localparam int CNT_BASE = 16;
  localparam int SEL_BASE = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 6'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 6'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 6'd2;
  localparam logic [ADDR_W-1:0] A_OVF_SET = 6'd3;
  localparam logic [ADDR_W-1:0] A_OVF_CLR = 6'd4;
  localparam logic [ADDR_W-1:0] A_IRQ_SET = 6'd5;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = 6'd6;
  localparam logic [ADDR_W-1:0] A_CYC_LO  = 6'd8;
  localparam logic [ADDR_W-1:0] A_CYC_HI  = 6'd9;
  localparam logic [ADDR_W-1:0] A_CYC_CFG = 6'd10;
endpackage

// File: rtl/pmu_evt_decode.sv
module pmu_evt_decode #(
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 10
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  // code 0: none, code 1: every cycle, code k+2: event line k
  always_comb begin
    hit_o = (sel_i == SEL_W'(1));
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel_i == SEL_W'(k + 2)) hit_o = evt_i[k];
    end
  end
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 10,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic               cnt_we,
  input  logic               sel_we,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [SEL_W-1:0]   sel_wdata,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               wrap_o
);
  logic hit;
  logic inc;

  pmu_evt_decode #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_dec (
    .sel_i(sel_o), .evt_i(evt_i), .hit_o(hit)
  );

  assign inc    = run_i && hit;
  assign wrap_o = inc && (&cnt_o) && !cnt_we && !clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      sel_o <= '0;
    end else begin
      if (sel_we) sel_o <= sel_wdata;
      if (clr_i)       cnt_o <= '0;
      else if (cnt_we) cnt_o <= wdata;
      else if (inc)    cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 10,
  parameter int HALF_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                en_i,
  input  logic                clr_i,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic                cfg_we,
  input  logic [HALF_W-1:0]   wdata,
  input  logic [SEL_W-1:0]    start_wdata,
  input  logic [SEL_W-1:0]    stop_wdata,
  output logic [2*HALF_W-1:0] cyc_o,
  output logic [SEL_W-1:0]    start_o,
  output logic [SEL_W-1:0]    stop_o,
  output logic                wrap_o
);
  localparam int CYC_W = 2 * HALF_W;

  logic start_hit, stop_hit, run, inc;

  pmu_evt_decode #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_start (
    .sel_i(start_o), .evt_i(evt_i), .hit_o(start_hit)
  );
  pmu_evt_decode #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_stop (
    .sel_i(stop_o), .evt_i(evt_i), .hit_o(stop_hit)
  );

  assign inc    = en_i && run;
  assign wrap_o = inc && (&cyc_o) && !clr_i && !lo_we && !hi_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      start_o <= '0;
      stop_o  <= '0;
    end else begin
      if (stop_hit)       run <= 1'b0;
      else if (start_hit) run <= 1'b1;
      if (cfg_we) begin
        start_o <= start_wdata;
        stop_o  <= stop_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cyc_o <= '0;
    else if (lo_we)    cyc_o[HALF_W-1:0] <= wdata;
    else if (hi_we)    cyc_o[CYC_W-1:HALF_W] <= wdata;
    else if (inc)      cyc_o <= cyc_o + CYC_W'(1);
  end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [5:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  localparam int MW    = NUM_CNT + 1;   // mask bits: counters then cycle
  localparam int CYC_W = 2 * DATA_W;

  logic             glb_en;
  logic [MW-1:0]    en_q, ovf_q, irqen_q;
  logic [MW-1:0]    wrap;
  logic [CNT_W-1:0] cnt_v [NUM_CNT];
  logic [SEL_W-1:0] sel_v [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0] cnt_we, sel_we;
  logic [CYC_W-1:0] cyc_v;
  logic [SEL_W-1:0] cfg_start, cfg_stop;
  logic             ev_clr, cyc_clr;
  logic [MW-1:0]    wmask;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [DATA_W-1:0] mask2word(input logic [MW-1:0] m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NUM_CNT-1:0] = m[NUM_CNT-1:0];
    w[CYC_BIT]     = m[NUM_CNT];
    return w;
  endfunction

  assign wmask   = {reg_wdata[CYC_BIT], reg_wdata[NUM_CNT-1:0]};
  assign ev_clr  = reg_wr && reg_addr == A_CTRL && reg_wdata[1];
  assign cyc_clr = reg_wr && reg_addr == A_CTRL && reg_wdata[2];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_we[g] = reg_wr && reg_addr == ADDR_W'(CNT_BASE + g);
    assign sel_we[g] = reg_wr && reg_addr == ADDR_W'(SEL_BASE + g);
    pmu_evt_counter #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .evt_i(evt_i),
      .run_i(glb_en && en_q[g]), .clr_i(ev_clr),
      .cnt_we(cnt_we[g]), .sel_we(sel_we[g]),
      .wdata(reg_wdata[CNT_W-1:0]), .sel_wdata(reg_wdata[SEL_W-1:0]),
      .cnt_o(cnt_v[g]), .sel_o(sel_v[g]), .wrap_o(wrap[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_v[g];
  end

  pmu_cycle_counter #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W), .HALF_W(DATA_W)) u_cyc (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .en_i(glb_en && en_q[NUM_CNT]), .clr_i(cyc_clr),
    .lo_we(reg_wr && reg_addr == A_CYC_LO),
    .hi_we(reg_wr && reg_addr == A_CYC_HI),
    .cfg_we(reg_wr && reg_addr == A_CYC_CFG),
    .wdata(reg_wdata),
    .start_wdata(reg_wdata[SEL_W-1:0]),
    .stop_wdata(reg_wdata[STOP_LSB +: SEL_W]),
    .cyc_o(cyc_v), .start_o(cfg_start), .stop_o(cfg_stop),
    .wrap_o(wrap[NUM_CNT])
  );

  // control and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en  <= 1'b0;
      en_q    <= '0;
      ovf_q   <= '0;
      irqen_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) glb_en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_EN_SET)  en_q <= en_q | wmask;
      if (reg_wr && reg_addr == A_EN_CLR)  en_q <= en_q & ~wmask;
      if (reg_wr && reg_addr == A_IRQ_SET) irqen_q <= irqen_q | wmask;
      if (reg_wr && reg_addr == A_IRQ_CLR) irqen_q <= irqen_q & ~wmask;
      if (reg_wr && reg_addr == A_OVF_SET)      ovf_q <= ovf_q | wmask | wrap;
      else if (reg_wr && reg_addr == A_OVF_CLR) ovf_q <= (ovf_q & ~wmask) | wrap;
      else                                      ovf_q <= ovf_q | wrap;
      irq_o <= |(ovf_q & irqen_q);
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:               rd_mux[0] = glb_en;
      A_EN_SET, A_EN_CLR:   rd_mux = mask2word(en_q);
      A_OVF_SET, A_OVF_CLR: rd_mux = mask2word(ovf_q);
      A_IRQ_SET, A_IRQ_CLR: rd_mux = mask2word(irqen_q);
      A_CYC_LO:             rd_mux = cyc_v[DATA_W-1:0];
      A_CYC_HI:             rd_mux = cyc_v[CYC_W-1:DATA_W];
      A_CYC_CFG: begin
        rd_mux[SEL_W-1:0]         = cfg_start;
        rd_mux[STOP_LSB +: SEL_W] = cfg_stop;
      end
      default: ;
    endcase
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + k)) rd_mux[CNT_W-1:0] = cnt_v[k];
      if (reg_addr == ADDR_W'(SEL_BASE + k)) rd_mux[SEL_W-1:0] = sel_v[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_wr,
  input logic [5:0]               reg_addr,
  input logic                     glb_en,
  input logic [NUM_CNT:0]         ovf_q,
  input logic [NUM_CNT:0]         irqen_q,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [63:0]              cyc_v,
  input logic                     irq_o
);
  // R8: interrupt line follows the masked flags one clock later
  assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(ovf_q & irqen_q)));

  // R7: a flag only falls after a write to the clear address
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (|($past(ovf_q) & ~ovf_q)) |-> $past(reg_wr && reg_addr == 6'd4));

  // R3: nothing counts with the global enable off and no write
  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!glb_en) && $past(!reg_wr)) |-> ($stable(cnt_flat) && $stable(cyc_v)));

  // R9: without writes the cycle counter moves by at most one
  assert_cyc_step_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!reg_wr) |-> (cyc_v == $past(cyc_v) || cyc_v == $past(cyc_v) + 64'd1));

  // R8: no enabled interrupt for two clocks keeps the line low
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(irqen_q) == '0) |-> !irq_o);
endmodule

bind perf_monitor pmu_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_pmu_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .glb_en(glb_en), .ovf_q(ovf_q), .irqen_q(irqen_q),
  .cnt_flat(cnt_flat), .cyc_v(cyc_v), .irq_o(irq_o)
);

// File: tb/perf_monitor_bench.sv
module perf_monitor_bench;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [NE-1:0] evt = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perf_monitor #(.NUM_EVT(NE)) u_perf_monitor (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rd(6'(a), d); chk("R1 reset register", d, 0);
    end
    rd(6'd16, d); chk("R1 reset counter", d, 0);
    chk("R1 reset irq", irq, 0);

    // R2/R3 selector sweep on each counter
    for (int i = 0; i < 4; i++) wr(6'(32 + i), 1);
    for (int i = 0; i < 4; i++) begin
      for (int s = 0; s < 8; s++) begin
        int exp;
        wr(6'(32 + i), 32'(s));
        wr(6'd0, 2);
        wr(6'd2, 32'hFFFF_FFFF);
        wr(6'd1, 32'(1) << i);
        wr(6'd0, 1);
        for (int j = 0; j < 10; j++) begin
          evt = 4'(j); @(negedge clk);
        end
        evt = '0;
        wr(6'd0, 0);
        exp = 0;
        if (s == 1) exp = 11;
        else if (s >= 2 && s < 2 + NE)
          for (int j = 0; j < 10; j++) exp += (j >> (s - 2)) & 1;
        rd(6'(16 + i), d); chk("R2 selector count", d, 32'(exp));
        rd(6'(16 + (i + 1) % 4), d); chk("R3 disabled counter held", d, 0);
        wr(6'(32 + i), 1);
      end
      rd(6'd1, d); chk("R4 enable readback", d, 32'(1) << i);
    end

    // R4 set/clear pairs
    wr(6'd2, 0);
    rd(6'd1, d); chk("R4 zero clear no effect", d, 8);
    wr(6'd1, 32'h8000_7FF5);
    rd(6'd2, d); chk("R4 set via ones", d, 32'h8000_000D);
    wr(6'd2, 9);
    rd(6'd1, d); chk("R4 clear via ones", d, 32'h8000_0004);

    // R6/R7/R8 preset, wrap, overflow, interrupt
    wr(6'd2, 32'hFFFF_FFFF);
    wr(6'd17, 32'hFFFF_FFFE);
    wr(6'd1, 2);
    wr(6'd5, 2);
    wr(6'd0, 1);
    repeat (2) @(negedge clk);
    wr(6'd0, 0);
    rd(6'd17, d); chk("R6 preset then wrap", d, 1);
    rd(6'd3, d); chk("R7 overflow flag", d, 2);
    chk("R8 irq raised", irq, 1);
    wr(6'd6, 2);
    rd(6'd5, d); chk("R4 irq enable cleared", d, 0);
    chk("R8 irq masked", irq, 0);
    wr(6'd5, 2);
    @(negedge clk);
    chk("R8 irq re-enabled", irq, 1);
    rd(6'd3, d); chk("R7 flag still sticky", d, 2);
    wr(6'd4, 2);
    rd(6'd3, d); chk("R7 flag cleared", d, 0);
    chk("R8 irq after clear", irq, 0);
    wr(6'd3, 8);
    rd(6'd4, d); chk("R4 overflow set by write", d, 8);
    wr(6'd4, 8);
    wr(6'd6, 32'hFFFF_FFFF);

    // R6 write beats increment
    wr(6'd1, 4);
    wr(6'd0, 1);
    wr(6'd18, 100);
    wr(6'd0, 0);
    rd(6'd18, d); chk("R6 write wins over count", d, 101);

    // R5 counter reset bits
    wr(6'd0, 6);
    rd(6'd0, d); chk("R5 reset bits read zero", d, 0);
    rd(6'd18, d); chk("R5 event counter zeroed", d, 0);

    // R9/R10 start/stop window
    wr(6'd2, 32'hFFFF_FFFF);
    wr(6'd1, 32'h8000_0000);
    wr(6'd8, 32'hFFFF_FFFF);
    wr(6'd9, 0);
    wr(6'd10, (32'd3 << 16) | 32'd2);
    rd(6'd10, d); chk("R10 config readback", d, 32'h0003_0002);
    wr(6'd0, 1);
    repeat (3) @(negedge clk);
    rd(6'd8, d); chk("R10 idle before start", d, 32'hFFFF_FFFF);
    evt = 4'b0001; @(negedge clk); evt = '0;
    repeat (5) @(negedge clk);
    evt = 4'b0010; @(negedge clk); evt = '0;
    rd(6'd8, d); chk("R9 low word after window", d, 5);
    rd(6'd9, d); chk("R9 carry into high word", d, 1);
    evt = 4'b0011; @(negedge clk); evt = '0;
    repeat (2) @(negedge clk);
    rd(6'd8, d); chk("R10 stop wins", d, 5);
    wr(6'd0, 5);
    rd(6'd8, d); chk("R5 cycle low zeroed", d, 0);
    rd(6'd9, d); chk("R5 cycle high zeroed", d, 0);

    // R9/R7 64-bit wrap
    wr(6'd0, 0);
    wr(6'd8, 32'hFFFF_FFFF);
    wr(6'd9, 32'hFFFF_FFFF);
    wr(6'd10, 1);
    wr(6'd0, 1);
    @(negedge clk);
    wr(6'd0, 0);
    rd(6'd8, d); chk("R9 wrap low", d, 1);
    rd(6'd9, d); chk("R9 wrap high", d, 0);
    rd(6'd3, d); chk("R7 cycle overflow bit 31", d, 32'h8000_0000);
    chk("R8 no irq without enable", irq, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule